// File: doc/BRIEF.md
# Long-Burst SPI Master

This block is an SPI master that runs a single chip-select frame whose length is programmed in bits, from 1 up to 4096. That length is independent of the 32-bit word size of the two FIFOs that feed and drain it. Software pushes transmit words into a FIFO and selects how a frame starts. In automatic start, a frame begins as soon as the transmit FIFO holds data. In software start, a frame begins only after a start bit has been written. Received bits are framed into 32-bit words the same way and pushed into a receive FIFO.

When the frame length is not a multiple of 32, the first word carries only the remainder bits in its low end. Every later word is shifted out whole. Chip select stays low across word boundaries. It is released after the last programmed bit, or sooner if the next word is needed and the transmit FIFO is empty.

The serial clock follows SPI mode 0. Its half period is set by a divider of the system clock, and the same half period is used as chip-select setup and hold time.

Top module: `spi_burst_top`

## Requirements
- R1: A length field value N (12 bits) produces exactly N+1 rising serial clock edges in the frame, provided enough transmit words are supplied.
- R2: Chip select goes low once per frame and stays low across all word boundaries until the frame ends.
- R3: If the transmit FIFO is empty when a new word is needed mid-frame, the frame ends after the bits already completed, and chip select is released.
- R4: Let F = (N+1) mod 32, or 32 when that is 0. The first word shifts its bits F-1 down to 0. Every later word shifts bits 31 down to 0. Bits go out MSB first on `mosi`.
- R5: `sclk` is low whenever chip select is high. `mosi` does not change while `sclk` is high. `miso` is sampled on the rising edge of `sclk`.
- R6: The first received word holds its F bits right-aligned, in arrival order, with the earliest bit most significant. Each later received word holds 32 bits. Each word is pushed to the receive FIFO once it is complete.
- R7: In automatic mode (`cfgSwStart`=0) a frame starts whenever the transmit FIFO is not empty. With N=7, each word becomes its own 8-bit frame, and chip select returns high between consecutive frames.
- R8: In software mode (`cfgSwStart`=1) no frame starts while `startBit` is 0, even when data is queued. A `startWr` pulse sets `startBit`, and `startBit` clears when the frame ends.
- R9: `busy` rises together with the falling edge of chip select and stays high until chip select is released.
- R10: Chip select falls at least one half period before the first rising `sclk` edge, and rises at least one half period after the last falling edge.
- R11: Each `sclk` high or low phase inside a frame lasts `cfgClkDiv`+1 system clock cycles.
- R12: A push into a full transmit FIFO (depth `FIFO_DEPTH`) is dropped, so only `FIFO_DEPTH` words can be queued ahead of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgBurstLen | input | 12 | Frame length minus one, in bits |
| cfgSwStart | input | 1 | 1: start needs the start bit; 0: start when data is queued |
| cfgClkDiv | input | DIV_W | Half-period length minus one, in system cycles |
| startWr | input | 1 | Pulse that sets the start bit |
| startBit | output | 1 | Start bit; clears at the end of a frame |
| busy | output | 1 | High while a frame is in progress |
| txPush | input | 1 | Push strobe for the transmit FIFO |
| txData | input | 32 | Transmit word |
| txFull | output | 1 | Transmit FIFO full |
| rxPop | input | 1 | Pop strobe for the receive FIFO |
| rxData | output | 32 | Head word of the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxFull | output | 1 | Receive FIFO full |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |

## Verification
The bench targets frame lengths around the word size: 1, 32, 33 and 4096 bits, plus random lengths in between. A design that misplaces the remainder would send the wrong high bits of the first word, or one word too many. A frame that needs more words than the FIFO holds checks that chip select stays low across word boundaries; a design that broke there would produce several frames instead of one. Starving the FIFO mid-frame checks the early release, which a wrong design would either skip (clocking out stale data) or take too early. Automatic mode with 8-bit frames checks that chip select toggles between words. A held-off software start checks that queued data does not start a frame on its own.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = LEN_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD
  } spiState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // take a fresh transmit word
    logic [4:0] alignSh;  // left shift that brings the first valid bit to the MSB
    logic       shift;    // advance the transmit shifter
    logic       sample;   // capture miso
  } dpStrobe_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16   // power of two
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgBurstLen,
  input  logic             cfgSwStart,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             startWr,
  input  logic             txEmpty,
  output logic             txPop,
  output logic             rxPush,
  output dpStrobe_t        stb,
  output logic             sclk,
  output logic             csN,
  output logic             busy,
  output logic             startBit
);
  spiState_t        state;
  logic [DIV_W-1:0] divCnt, divLat;
  logic [CNT_W-1:0] bitsLeft, lenPlus;
  logic [5:0]       wordLeft, firstBits, alignTmp;
  logic             tick, begin_, wordEnd, lastBit, done;

  assign lenPlus   = {1'b0, cfgBurstLen} + 1'b1;
  assign firstBits = (lenPlus[4:0] == '0) ? 6'd32 : {1'b0, lenPlus[4:0]};
  assign alignTmp  = 6'd32 - firstBits;

  assign tick    = (divCnt == divLat);
  assign begin_  = (state == ST_IDLE) && !txEmpty && (!cfgSwStart || startBit);
  assign wordEnd = (state == ST_HIGH) && tick && (wordLeft == 6'd1);
  assign lastBit = (bitsLeft == CNT_W'(1));
  assign done    = (state == ST_HOLD) && tick;
  assign busy    = (state != ST_IDLE);

  assign txPop       = begin_ || (wordEnd && !lastBit && !txEmpty);
  assign rxPush      = wordEnd;
  assign stb.load    = txPop;
  assign stb.alignSh = begin_ ? alignTmp[4:0] : 5'd0;
  assign stb.shift   = (state == ST_HIGH) && tick && (wordLeft != 6'd1) && !lastBit;
  assign stb.sample  = tick && ((state == ST_SETUP) || (state == ST_LOW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (state == ST_IDLE || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startBit <= 1'b0;
    else if (done) startBit <= 1'b0;
    else if (startWr) startBit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      bitsLeft <= '0;
      wordLeft <= '0;
      divLat   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (begin_) begin
          state    <= ST_SETUP;
          csN      <= 1'b0;
          bitsLeft <= lenPlus;
          wordLeft <= firstBits;
          divLat   <= cfgClkDiv;
        end
        ST_SETUP, ST_LOW: if (tick) begin
          sclk  <= 1'b1;
          state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk     <= 1'b0;
          bitsLeft <= bitsLeft - 1'b1;
          if (lastBit) state <= ST_HOLD;
          else if (wordLeft == 6'd1) begin
            if (txEmpty) state <= ST_HOLD;
            else begin
              wordLeft <= 6'd32;
              state    <= ST_LOW;
            end
          end else begin
            wordLeft <= wordLeft - 1'b1;
            state    <= ST_LOW;
          end
        end
        ST_HOLD: if (tick) begin
          csN   <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              misoIn,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txSh, rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (stb.load) txSh <= txWord << stb.alignSh;
      else if (stb.shift) txSh <= {txSh[WORD_W-2:0], 1'b0};
      if (stb.load) rxSh <= '0;
      else if (stb.sample) rxSh <= {rxSh[WORD_W-2:0], misoIn};
    end
  end

  assign mosi   = txSh[WORD_W-1];
  assign rxWord = rxSh;
endmodule

// File: rtl/spi_burst_top.sv
module spi_burst_top
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [11:0]      cfgBurstLen,
  input  logic             cfgSwStart,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             startWr,
  output logic             startBit,
  output logic             busy,
  input  logic             txPush,
  input  logic [31:0]      txData,
  output logic             txFull,
  input  logic             rxPop,
  output logic [31:0]      rxData,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             csN
);
  dpStrobe_t         stb;
  logic              txPop, txEmpty, rxPush;
  logic [WORD_W-1:0] txWord, rxWord;

  spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .pushData(txData), .full(txFull),
    .pop(txPop), .popData(txWord), .empty(txEmpty));

  spi_burst_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData(rxWord), .full(rxFull),
    .pop(rxPop), .popData(rxData), .empty(rxEmpty));

  spi_burst_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgBurstLen(cfgBurstLen), .cfgSwStart(cfgSwStart),
    .cfgClkDiv(cfgClkDiv), .startWr(startWr), .txEmpty(txEmpty), .txPop(txPop),
    .rxPush(rxPush), .stb(stb), .sclk(sclk), .csN(csN), .busy(busy),
    .startBit(startBit));

  spi_burst_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord), .misoIn(miso),
    .mosi(mosi), .rxWord(rxWord));
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk (
  input logic clk,
  input logic rstN,
  input logic cfgSwStart,
  input logic startBit,
  input logic busy,
  input logic sclk,
  input logic mosi,
  input logic csN
);
  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $fell(csN));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $rose(csN));

  assert_cs_setup_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);

  assert_cs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !$past(sclk));

  assert_no_sw_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSwStart && !startBit && csN && !busy) |=> csN);

  assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> $rose(csN));
endmodule

bind spi_burst_top spi_burst_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgSwStart(cfgSwStart), .startBit(startBit),
  .busy(busy), .sclk(sclk), .mosi(mosi), .csN(csN));

// File: tb/sim_spi_burst_top.sv
module sim_spi_burst_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [11:0] cfgBurstLen = '0;
  logic        cfgSwStart = 1'b1;
  logic [7:0]  cfgClkDiv = '0;
  logic        startWr = 1'b0, txPush = 1'b0, rxPop = 1'b0;
  logic [31:0] txData = '0;
  logic        startBit, busy, txFull, rxEmpty, rxFull, sclk, mosi, miso, csN;
  logic [31:0] rxData;

  always #2 clk = ~clk;

  spi_burst_top #(.FIFO_DEPTH(DEPTH), .DIV_W(8)) u0 (
    .clk(clk), .rstN(rstN), .cfgBurstLen(cfgBurstLen), .cfgSwStart(cfgSwStart),
    .cfgClkDiv(cfgClkDiv), .startWr(startWr), .startBit(startBit), .busy(busy),
    .txPush(txPush), .txData(txData), .txFull(txFull), .rxPop(rxPop),
    .rxData(rxData), .rxEmpty(rxEmpty), .rxFull(rxFull), .sclk(sclk),
    .mosi(mosi), .miso(miso), .csN(csN));

  int checks = 0, fails = 0;
  logic [31:0] txW [0:255];
  logic [31:0] rxGot [0:255];
  bit misoBits [0:4096];
  bit gotBits [0:4095];

  // serial monitor, sampled on the falling clock edge
  int  cyc = 0, lastEdge = 0, lastCsFall = 0, nBits = 0, curDiv = 0;
  int  burstsBegun = 0, burstsDone = 0, lastBurstBits = 0, timErr = 0, modeErr = 0;
  bit  pSclk = 0, pCs = 1, pMosi = 0;

  assign miso = misoBits[nBits];

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (pCs && !csN) begin
        burstsBegun++; nBits = 0; lastCsFall = cyc; lastEdge = cyc;
      end
      if (!pSclk && sclk) begin
        if (nBits == 0) begin
          if (cyc - lastCsFall < curDiv + 1) timErr++;
        end else if (cyc - lastEdge != curDiv + 1) timErr++;
        if (nBits < 4096) gotBits[nBits] = mosi;
        nBits++; lastEdge = cyc;
      end
      if (pSclk && !sclk) begin
        if (cyc - lastEdge != curDiv + 1) timErr++;
        lastEdge = cyc;
      end
      if (pSclk && sclk && (mosi != pMosi)) modeErr++;
      if (csN && sclk) modeErr++;
      if (!pCs && csN) begin
        if (cyc - lastEdge < curDiv + 1) timErr++;
        burstsDone++; lastBurstBits = nBits;
      end
    end
    pSclk = sclk; pCs = csN; pMosi = mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int firstOf(input int n);
    int r = (n + 1) % 32;
    return (r == 0) ? 32 : r;
  endfunction

  function automatic bit expTxBit(input int k, input int first);
    if (k < first) return txW[0][first-1-k];
    return txW[(k-first)/32 + 1][31 - ((k-first) % 32)];
  endfunction

  function automatic logic [31:0] expRx(input int j, input int first);
    logic [31:0] v = '0;
    int base = (j == 0) ? 0 : first + 32*(j-1);
    int cnt  = (j == 0) ? first : 32;
    for (int i = 0; i < cnt; i++) v = {v[30:0], misoBits[base+i]};
    return v;
  endfunction

  task automatic runBurst(input int n, input int nWords, input int div,
                          input bit preAll, input int idleWait, input string tag);
    int first = firstOf(n);
    int need  = 1 + (n + 1 - first) / 32;
    int eff   = (preAll && nWords > DEPTH) ? DEPTH : nWords;
    int sent  = (eff < need) ? eff : need;
    int expBits = (eff >= need) ? n + 1 : first + 32*(eff-1);
    int pre   = preAll ? nWords : ((nWords < DEPTH) ? nWords : DEPTH);
    int base  = burstsDone, begun = burstsBegun, rxN = 0, bad = 0, i = 0;
    int t0e = timErr, m0e = modeErr;
    cfgBurstLen = 12'(n); cfgClkDiv = 8'(div); curDiv = div; cfgSwStart = 1'b1;
    for (int k = 0; k < nWords; k++) txW[k] = $urandom;
    for (int k = 0; k < 4097; k++) misoBits[k] = 1'($urandom);
    while (i < pre) begin
      @(negedge clk); txPush = 1'b1; txData = txW[i]; i++;
    end
    @(negedge clk); txPush = 1'b0;
    if (idleWait > 0) begin
      repeat (idleWait) @(negedge clk);
      check(csN && !busy && burstsBegun == begun, "R8", "no start without start bit",
            burstsBegun - begun, 0);
    end
    startWr = 1'b1; @(negedge clk); startWr = 1'b0; @(negedge clk);
    check(busy && !csN, "R9", "busy and cs low after start", {busy, csN}, 2'b10);
    fork
      begin
        while (i < nWords) begin
          @(negedge clk);
          if (!txFull) begin txPush = 1'b1; txData = txW[i]; i++; end
          else txPush = 1'b0;
        end
        @(negedge clk); txPush = 1'b0;
      end
      begin
        forever begin
          @(negedge clk);
          if (!rxEmpty) begin rxGot[rxN] = rxData; rxN++; rxPop = 1'b1; end
          else begin
            rxPop = 1'b0;
            if (burstsDone > base) break;
          end
        end
      end
    join
    check(burstsDone - base == 1 && burstsBegun - begun == 1, "R2",
          {tag, " single cs frame"}, burstsBegun - begun, 1);
    check(lastBurstBits == expBits, (eff < need) ? "R3" : "R1",
          {tag, " bit count"}, lastBurstBits, expBits);
    for (int k = 0; k < expBits && k < 4096; k++)
      if (gotBits[k] != expTxBit(k, first)) bad++;
    check(bad == 0, "R4", {tag, " mosi bit errors"}, bad, 0);
    bad = 0;
    for (int j = 0; j < sent && j < rxN; j++) if (rxGot[j] !== expRx(j, first)) bad++;
    check(rxN == sent && bad == 0, "R6", {tag, " rx words"}, rxN*1000 + bad, sent*1000);
    check(timErr == t0e, "R11", {tag, " half-period/setup/hold errors (R10)"},
          timErr - t0e, 0);
    check(modeErr == m0e, "R5", {tag, " mode 0 errors"}, modeErr - m0e, 0);
    check(!startBit && !busy, "R8", {tag, " start bit cleared"}, {startBit, busy}, 0);
  endtask

  task automatic autoTest();
    int base = burstsDone, rxN = 0, bad = 0, t = 0;
    cfgBurstLen = 12'd7; cfgClkDiv = 8'd1; curDiv = 1; cfgSwStart = 1'b0;
    for (int k = 0; k < 4097; k++) misoBits[k] = 1'($urandom);
    for (int k = 0; k < 3; k++) begin
      txW[k] = $urandom;
      @(negedge clk); txPush = 1'b1; txData = txW[k];
    end
    @(negedge clk); txPush = 1'b0;
    while (burstsDone - base < 3 && t < 2000) begin @(negedge clk); t++; end
    check(burstsDone - base == 3, "R7", "auto mode separate frames", burstsDone - base, 3);
    check(lastBurstBits == 8, "R7", "auto mode frame length", lastBurstBits, 8);
    for (int k = 0; k < 8; k++) if (gotBits[k] != txW[2][7-k]) bad++;
    check(bad == 0, "R7", "auto mode last word low byte", bad, 0);
    bad = 0;
    while (!rxEmpty) begin
      @(negedge clk);
      if (!rxEmpty) begin rxGot[rxN] = rxData; rxN++; rxPop = 1'b1; end
      else rxPop = 1'b0;
      @(negedge clk); rxPop = 1'b0;
    end
    for (int j = 0; j < rxN; j++) if (rxGot[j] !== expRx(0, 8)) bad++;
    check(rxN == 3 && bad == 0, "R6", "auto mode rx bytes", rxN*1000 + bad, 3000);
    cfgSwStart = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN && !sclk && !busy && !startBit && rxEmpty && !txFull, "R9",
          "reset state", {csN, sclk, busy, startBit, rxEmpty}, 5'b10001);
    runBurst(7,    1,   0, 0, 40, "len8 held start");
    runBurst(0,    1,   1, 0, 0,  "len1");
    runBurst(31,   1,   2, 0, 0,  "len32");
    runBurst(32,   2,   0, 0, 0,  "len33");
    runBurst(4095, 128, 0, 0, 0,  "len4096");
    runBurst(99,   2,   1, 0, 0,  "underflow");
    runBurst(4095, DEPTH + 3, 0, 1, 0, "full fifo R12");
    autoTest();
    for (int r = 0; r < 8; r++) begin
      int n = $urandom_range(300, 0);
      runBurst(n, 1 + (n + 1 - firstOf(n)) / 32, $urandom_range(3, 0), 0, 0, "random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule